// File: doc/BRIEF.md
# Next Program Counter Selector

This combinational block picks the program counter that a word-addressed core fetches from next. Each cycle the core states what kind of control transfer the current instruction performs. The possible kinds are a plain step to the following instruction, a jump to an absolute address carried in the instruction, a jump through the 16-bit Z pointer, a jump through Z widened by an upper extension register, and a branch relative to the current PC. The block returns the resulting address.

Branch conditions are resolved elsewhere. The core only presents the relative kind when the branch is taken, and it fetches from the returned address itself. All address arithmetic is done modulo the PC width, so a transfer past the top or bottom of program space wraps around.

Top module: `next_pc_sel`

## Requirements
- R1: With kind code 0 (step) and the long-instruction flag low, next_pc equals cur_pc + 1.
- R2: With kind code 0 and the long-instruction flag high, next_pc equals cur_pc + 2, which skips the second word of a two-word instruction.
- R3: With kind code 1 (absolute), next_pc equals abs_tgt, and the long-instruction flag has no effect.
- R4: With kind code 2 (pointer), next_pc equals zptr zero-extended to the PC width, and ext_hi has no effect.
- R5: With kind code 3 (extended pointer), next_pc equals ext_hi in the upper PC_W-16 bits and zptr in the lower 16 bits.
- R6: With kind code 4 (relative), next_pc equals cur_pc + k + 1. Here k is rel_off read as a 12-bit two's-complement number in the range -2048 to 2047, and the long-instruction flag has no effect.
- R7: Every sum wraps modulo 2^22. Stepping from the top address gives 0 or 1, and a relative branch past either end wraps around.
- R8: Kind codes 5, 6 and 7 are treated as a step, including the +2 case when the long-instruction flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_pc | input | 22 | Word address of the current instruction |
| kind | input | 3 | Control-transfer kind: 0 step, 1 absolute, 2 pointer, 3 extended pointer, 4 relative |
| long_insn | input | 1 | Current instruction occupies two words |
| rel_off | input | 12 | Signed relative offset k |
| abs_tgt | input | 22 | Absolute target taken from the instruction |
| zptr | input | 16 | Z pointer value |
| ext_hi | input | 6 | Extension bits placed above Z for the extended pointer kind |
| next_pc | output | 22 | Selected next program counter |

## Verification
The bench builds the block with its default widths: a 22-bit PC, a 16-bit Z pointer and a 12-bit offset. With these widths the exact offset endpoints -2048 and 2047 and the 6-bit extension field can be applied directly, and the wrap at 2^22 can be reached from both sides with single relative branches and steps that start at the top address. It also applies the spare kind codes and toggles inputs that should have no effect, then checks that the output does not move.

// File: rtl/next_pc_sel.sv
module next_pc_sel #(
  parameter int PC_W  = 22,
  parameter int Z_W   = 16,
  parameter int OFF_W = 12
) (
  input  logic [PC_W-1:0]      cur_pc,
  input  logic [2:0]           kind,
  input  logic                 long_insn,
  input  logic [OFF_W-1:0]     rel_off,
  input  logic [PC_W-1:0]      abs_tgt,
  input  logic [Z_W-1:0]       zptr,
  input  logic [PC_W-Z_W-1:0]  ext_hi,
  output logic [PC_W-1:0]      next_pc
);
  localparam int EXT_W = PC_W - Z_W;

  typedef enum logic [2:0] {
    K_STEP = 3'd0,
    K_ABS  = 3'd1,
    K_PTR  = 3'd2,
    K_XPTR = 3'd3,
    K_REL  = 3'd4
  } kind_e;

  logic [PC_W-1:0] step_tgt, rel_tgt, ptr_tgt, xptr_tgt, k_ext;

  assign k_ext    = {{(PC_W-OFF_W){rel_off[OFF_W-1]}}, rel_off};
  assign step_tgt = cur_pc + {{(PC_W-2){1'b0}}, long_insn, ~long_insn};
  assign rel_tgt  = cur_pc + k_ext + PC_W'(1);
  assign ptr_tgt  = {{EXT_W{1'b0}}, zptr};
  assign xptr_tgt = {ext_hi, zptr};

  always_comb begin
    case (kind)
      K_ABS:   next_pc = abs_tgt;
      K_PTR:   next_pc = ptr_tgt;
      K_XPTR:  next_pc = xptr_tgt;
      K_REL:   next_pc = rel_tgt;
      default: next_pc = step_tgt;
    endcase
  end

  logic [PC_W-1:0] fwd, rel_diff;
  assign fwd      = next_pc - cur_pc;
  assign rel_diff = next_pc - cur_pc - PC_W'(1);

  always_comb begin
    if (kind == K_STEP && !long_insn)
      assert_step_one_R1: assert (fwd == PC_W'(1));
    if (kind == K_STEP && long_insn)
      assert_step_two_R2: assert (fwd == PC_W'(2));
    if (kind == K_ABS)
      assert_abs_load_R3: assert (next_pc == abs_tgt);
    if (kind == K_PTR)
      assert_ptr_zext_R4: assert (next_pc[PC_W-1:Z_W] == '0 && next_pc[Z_W-1:0] == zptr);
    if (kind == K_XPTR)
      assert_xptr_concat_R5: assert (next_pc[PC_W-1:Z_W] == ext_hi && next_pc[Z_W-1:0] == zptr);
    if (kind == K_REL)
      assert_rel_span_R6: assert (rel_diff[OFF_W-1:0] == rel_off &&
                                  (&rel_diff[PC_W-1:OFF_W-1] || ~|rel_diff[PC_W-1:OFF_W-1]));
    if (kind > K_REL)
      assert_spare_step_R8: assert (fwd == (long_insn ? PC_W'(2) : PC_W'(1)));
  end
endmodule

// File: tb/test_next_pc_sel.sv
module test_next_pc_sel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [21:0] cur_pc = '0, abs_tgt = '0, next_pc;
  logic [2:0]  kind = '0;
  logic        long_insn = 1'b0;
  logic [11:0] rel_off = '0;
  logic [15:0] zptr = '0;
  logic [5:0]  ext_hi = '0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  next_pc_sel i_next_pc_sel (
    .cur_pc(cur_pc), .kind(kind), .long_insn(long_insn), .rel_off(rel_off),
    .abs_tgt(abs_tgt), .zptr(zptr), .ext_hi(ext_hi), .next_pc(next_pc)
  );

  task automatic apply(input logic [21:0] pc, input logic [2:0] k, input logic lg,
                       input logic [11:0] off, input logic [21:0] at,
                       input logic [15:0] z, input logic [5:0] eh);
    @(posedge clk);
    cur_pc = pc; kind = k; long_insn = lg; rel_off = off;
    abs_tgt = at; zptr = z; ext_hi = eh;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [21:0] exp);
    n_cmp++;
    if (next_pc !== exp) begin
      n_bad++;
      $display("FAIL %s: next_pc=%06h expected=%06h", req, next_pc, exp);
    end
  endtask

  task automatic t_idle();
    apply(22'h0, 3'd0, 1'b0, 12'h0, 22'h0, 16'h0, 6'h0);
    check("R1 idle", 22'h000001);
  endtask

  task automatic t_step();
    apply(22'h000100, 3'd0, 1'b0, 12'h5A5, 22'h3ABCDE, 16'hFFFF, 6'h3F);
    check("R1 step", 22'h000101);
    apply(22'h1F00FF, 3'd0, 1'b1, 12'h000, 22'h0, 16'h0, 6'h0);
    check("R2 long step", 22'h1F0101);
  endtask

  task automatic t_abs();
    apply(22'h001234, 3'd1, 1'b0, 12'h800, 22'h2ABCDE, 16'h1111, 6'h15);
    check("R3 abs", 22'h2ABCDE);
    apply(22'h001234, 3'd1, 1'b1, 12'h800, 22'h2ABCDE, 16'h1111, 6'h15);
    check("R3 abs long ignored", 22'h2ABCDE);
  endtask

  task automatic t_ptr();
    apply(22'h3FFFFF, 3'd2, 1'b0, 12'h0, 22'h0, 16'hBEEF, 6'h00);
    check("R4 ptr", 22'h00BEEF);
    apply(22'h3FFFFF, 3'd2, 1'b1, 12'h0, 22'h0, 16'hBEEF, 6'h3F);
    check("R4 ptr ext ignored", 22'h00BEEF);
  endtask

  task automatic t_xptr();
    apply(22'h000010, 3'd3, 1'b0, 12'h0, 22'h0, 16'hBEEF, 6'h2A);
    check("R5 xptr", 22'h2ABEEF);
    apply(22'h000010, 3'd3, 1'b0, 12'h0, 22'h0, 16'h0001, 6'h3F);
    check("R5 xptr top", 22'h3F0001);
  endtask

  task automatic t_rel();
    apply(22'h000100, 3'd4, 1'b0, 12'h7FF, 22'h0, 16'h0, 6'h0);
    check("R6 rel max", 22'h000900);
    apply(22'h000100, 3'd4, 1'b1, 12'h800, 22'h0, 16'h0, 6'h0);
    check("R6 rel min long ignored", 22'h3FF901);
    apply(22'h001234, 3'd4, 1'b0, 12'hFFF, 22'h0, 16'h0, 6'h0);
    check("R6 rel -1", 22'h001234);
    apply(22'h001234, 3'd4, 1'b0, 12'h000, 22'h0, 16'h0, 6'h0);
    check("R6 rel 0", 22'h001235);
  endtask

  task automatic t_wrap();
    apply(22'h3FFFFF, 3'd0, 1'b0, 12'h0, 22'h0, 16'h0, 6'h0);
    check("R7 step wrap", 22'h000000);
    apply(22'h3FFFFF, 3'd0, 1'b1, 12'h0, 22'h0, 16'h0, 6'h0);
    check("R7 long wrap", 22'h000001);
    apply(22'h3FFFF0, 3'd4, 1'b0, 12'h7FF, 22'h0, 16'h0, 6'h0);
    check("R7 rel up wrap", 22'h0007F0);
    apply(22'h000005, 3'd4, 1'b0, 12'h800, 22'h0, 16'h0, 6'h0);
    check("R7 rel down wrap", 22'h3FF806);
  endtask

  task automatic t_spare();
    for (int c = 5; c < 8; c++) begin
      apply(22'h020000, 3'(c), 1'b0, 12'h123, 22'h3FFFFF, 16'hAAAA, 6'h11);
      check($sformatf("R8 kind %0d", c), 22'h020001);
      apply(22'h020000, 3'(c), 1'b1, 12'h123, 22'h3FFFFF, 16'hAAAA, 6'h11);
      check($sformatf("R8 kind %0d long", c), 22'h020002);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_step();
    t_abs();
    t_ptr();
    t_xptr();
    t_rel();
    t_wrap();
    t_spare();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule